// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block lets running software change on-chip nonvolatile memory. Software turns the function on through a protected control register. It loads a 16-bit target address as two bytes, a data byte and an operation code, then sets a start bit. From the cycle after the start bit is written, the block holds the processor through a stall output. It checks the request, runs the memory operation for a duration set by its own timer, then drops the start bit and the stall together.

The outcome is kept in a sticky failure flag. A request is refused without touching memory in three cases: the operation code is undefined, the target region's update enable is clear, or the brown-out inhibit condition holds. The memory array is outside the block. The block drives a request level for the whole pulse and a one-cycle commit strobe on the last pulse cycle. A read captures the array byte into the data register during that strobe.

Top module: `fsp_seq`

## Requirements
- R1: After reset every register reads zero and `cpu_stall`, `mem_req` and `mem_commit` are low. Register addresses: 0 control (bit 0 function enable, bit 1 failure flag), 1 start (bit 0), 2 address high byte, 3 address low byte, 4 data byte, 5 operation code (bits 1:0), 6 region update enables (one bit per region).
- R2: Writes to the control register and to the start register take effect only while `prot_open` is high.
- R3: Writing 1 to the start bit starts nothing while the function enable is 0. The stall stays low and the start bit reads 0.
- R4: The address high and low bytes, the data byte, the operation code and the region enables read back as written.
- R5: `cpu_stall` rises in the cycle after an accepted start write and stays high until the operation ends. The start bit reads 1 meanwhile and reads 0 once the operation has ended.
- R6: Operation code 2'b01 (byte program) runs a pulse of CLK_HZ*PROG_NS/1e9 cycles. The stall lasts that count plus 2 cycles, and one commit carries the target address and data byte.
- R7: Operation code 2'b10 (page erase) runs a pulse of CLK_HZ*ERASE_NS/1e9 cycles. The stall lasts that count plus 2 cycles, with one commit at the target address.
- R8: Operation code 2'b00 (read) runs a one-cycle pulse (stall of 3 cycles). It loads `mem_rdata` into the data register.
- R9: The region is the top log2(N_REGIONS) address bits. A program or erase aimed at a region whose enable bit is 0 makes no commit, sets the failure flag and stalls for 2 cycles.
- R10: Operation code 2'b11 makes no commit, sets the failure flag and stalls for 2 cycles.
- R11: A program or erase with `bo_inhibit_cfg`, `bod_enable` and `vdd_low` all high makes no commit and sets the failure flag. With any one of the three low, it runs normally.
- R12: The failure flag takes the outcome of each operation and so clears on a success. A protected control write with bit 1 at 0 clears it. Writing 1 never sets it.
- R13: Register writes arriving while an operation is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| prot_open | input | 1 | Protected-write window is open |
| bo_inhibit_cfg | input | 1 | Configuration: brown-out inhibits program and erase |
| bod_enable | input | 1 | Brown-out detection enabled |
| vdd_low | input | 1 | Supply below brown-out threshold |
| cpu_stall | output | 1 | Hold the processor program counter |
| mem_req | output | 1 | Memory operation pulse active |
| mem_commit | output | 1 | Last pulse cycle: apply the operation |
| mem_op | output | 2 | Operation code to the array |
| mem_addr | output | 16 | Target address |
| mem_wdata | output | 8 | Byte to program |
| mem_rdata | input | 8 | Array byte at `mem_addr` |

## Verification
The hardest cases to reach are the refusal paths. Brown-out inhibit needs three independent inputs high together, and the region check depends on both the top address bits and the per-region enable mask. The stimulus therefore draws address, mask, operation code and all three brown-out inputs at random, and adds directed cases with exactly one brown-out input low and a read aimed at a disabled region. A write issued in the middle of a running pulse is placed at a fixed point in the stall. The bench then reads the register back to show the write was ignored.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_BAD   = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PULSE  = 2'd1,
      ST_FINISH = 2'd2
   } seq_st_e;

   localparam logic [2:0] RA_CTRL    = 3'd0;
   localparam logic [2:0] RA_TRIG    = 3'd1;
   localparam logic [2:0] RA_ADDR_HI = 3'd2;
   localparam logic [2:0] RA_ADDR_LO = 3'd3;
   localparam logic [2:0] RA_DATA    = 3'd4;
   localparam logic [2:0] RA_OP      = 3'd5;
   localparam logic [2:0] RA_REGION  = 3'd6;

   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_FAIL_BIT = 1;
endpackage

// File: rtl/fsp_regs.sv
module fsp_regs
   import fsp_pkg::*;
#(
   parameter int unsigned N_REGIONS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           reg_addr,
   input  logic [7:0]           wdata,
   output logic [7:0]           rdata,
   input  logic                 prot_open,
   input  logic                 op_done,
   input  logic                 op_fail,
   input  logic                 rd_load,
   input  logic [7:0]           rd_byte,
   output logic                 go,
   output logic [15:0]          tgt_addr,
   output logic [7:0]           wr_byte,
   output logic [1:0]           op_code,
   output logic [N_REGIONS-1:0] region_en
);
   logic                 en_q, fail_q, go_q;
   logic [7:0]           ahi_q, alo_q, dat_q;
   logic [1:0]           op_q;
   logic [N_REGIONS-1:0] rgn_q;
   logic [7:0]           rgn_rd;
   logic                 host_ok;

   assign host_ok = wr_en && !go_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         fail_q <= 1'b0;
         go_q   <= 1'b0;
         ahi_q  <= '0;
         alo_q  <= '0;
         dat_q  <= '0;
         op_q   <= '0;
         rgn_q  <= '0;
      end else begin
         if (host_ok && prot_open && reg_addr == RA_CTRL) begin
            en_q <= wdata[CTRL_EN_BIT];
            if (!wdata[CTRL_FAIL_BIT]) fail_q <= 1'b0;
         end
         if (host_ok && prot_open && en_q && reg_addr == RA_TRIG && wdata[0])
            go_q <= 1'b1;
         if (host_ok && reg_addr == RA_ADDR_HI) ahi_q <= wdata;
         if (host_ok && reg_addr == RA_ADDR_LO) alo_q <= wdata;
         if (host_ok && reg_addr == RA_DATA)    dat_q <= wdata;
         if (host_ok && reg_addr == RA_OP)      op_q  <= wdata[1:0];
         if (host_ok && reg_addr == RA_REGION)  rgn_q <= wdata[N_REGIONS-1:0];
         if (rd_load) dat_q <= rd_byte;
         if (op_done) begin
            go_q   <= 1'b0;
            fail_q <= op_fail;
         end
      end
   end

   generate
      if (N_REGIONS < 8) begin : g_rgn_pad
         assign rgn_rd = {{(8 - N_REGIONS){1'b0}}, rgn_q};
      end else begin : g_rgn_full
         assign rgn_rd = rgn_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (reg_addr)
         RA_CTRL:    rdata = {6'd0, fail_q, en_q};
         RA_TRIG:    rdata = {7'd0, go_q};
         RA_ADDR_HI: rdata = ahi_q;
         RA_ADDR_LO: rdata = alo_q;
         RA_DATA:    rdata = dat_q;
         RA_OP:      rdata = {6'd0, op_q};
         RA_REGION:  rdata = rgn_rd;
         default:    rdata = '0;
      endcase
   end

   assign go        = go_q;
   assign tgt_addr  = {ahi_q, alo_q};
   assign wr_byte   = dat_q;
   assign op_code   = op_q;
   assign region_en = rgn_q;

   assert_trigger_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(go_q) |-> ($past(en_q) && $past(prot_open)));

   assert_busy_writes_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (go_q && $past(go_q)) |-> $stable({ahi_q, alo_q, op_q, rgn_q}));
endmodule

// File: rtl/fsp_timer.sv
module fsp_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
   import fsp_pkg::*;
#(
   parameter int unsigned CW          = 8,
   parameter logic [CW-1:0] PROG_LD   = '0,
   parameter logic [CW-1:0] ERASE_LD  = '0,
   parameter logic [CW-1:0] READ_LD   = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [1:0]    op_code,
   input  logic          region_ok,
   input  logic          inhibit,
   input  logic          expired,
   output logic          timer_load,
   output logic [CW-1:0] load_val,
   output logic          mem_req,
   output logic          mem_commit,
   output logic          op_done,
   output logic          op_fail
);
   seq_st_e st_q, st_d;
   logic    fail_q;
   logic    modify, reject;

   assign modify = (op_code == OP_PROG) || (op_code == OP_ERASE);
   assign reject = (op_code == OP_BAD) || (modify && (!region_ok || inhibit));

   always_comb begin
      st_d       = st_q;
      timer_load = 1'b0;
      case (st_q)
         ST_IDLE: if (go) begin
            if (reject) st_d = ST_FINISH;
            else begin
               st_d       = ST_PULSE;
               timer_load = 1'b1;
            end
         end
         ST_PULSE:  if (expired) st_d = ST_FINISH;
         ST_FINISH: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      case (op_code)
         OP_PROG:  load_val = PROG_LD;
         OP_ERASE: load_val = ERASE_LD;
         default:  load_val = READ_LD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fail_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && go) fail_q <= reject;
      end
   end

   assign mem_req    = (st_q == ST_PULSE);
   assign mem_commit = (st_q == ST_PULSE) && expired;
   assign op_done    = (st_q == ST_FINISH);
   assign op_fail    = fail_q;

   assert_pulse_only_when_started_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |-> go);
endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
   import fsp_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 24_000_000,
   parameter int unsigned N_REGIONS = 4,
   parameter int unsigned PROG_NS   = 23_500,
   parameter int unsigned ERASE_NS  = 5_000_000,
   parameter int unsigned READ_CYC  = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        prot_open,
   input  logic        bo_inhibit_cfg,
   input  logic        bod_enable,
   input  logic        vdd_low,
   output logic        cpu_stall,
   output logic        mem_req,
   output logic        mem_commit,
   output logic [1:0]  mem_op,
   output logic [15:0] mem_addr,
   output logic [7:0]  mem_wdata,
   input  logic [7:0]  mem_rdata
);
   localparam longint unsigned NS_PER_S  = 64'd1_000_000_000;
   localparam int unsigned PROG_CYC  = int'((64'(CLK_HZ) * 64'(PROG_NS)) / NS_PER_S);
   localparam int unsigned ERASE_CYC = int'((64'(CLK_HZ) * 64'(ERASE_NS)) / NS_PER_S);
   localparam int unsigned MAX_A     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int unsigned MAX_CYC   = (MAX_A > READ_CYC) ? MAX_A : READ_CYC;
   localparam int unsigned CW        = $clog2(MAX_CYC + 1);

   generate
      if (PROG_CYC < 1 || ERASE_CYC < 1 || READ_CYC < 1) begin : g_bad_timing
         $error("fsp_seq: every pulse must last at least one clock cycle");
      end
      if (N_REGIONS < 1 || N_REGIONS > 8 || (N_REGIONS & (N_REGIONS - 1)) != 0) begin : g_bad_regions
         $error("fsp_seq: N_REGIONS must be a power of two from 1 to 8");
      end
   endgenerate

   logic                 go, expired, timer_load, op_done, op_fail, rd_load;
   logic                 region_ok, inhibit;
   logic [15:0]          tgt_addr;
   logic [7:0]           wr_byte;
   logic [1:0]           op_code;
   logic [N_REGIONS-1:0] region_en;
   logic [CW-1:0]        load_val;

   fsp_regs #(.N_REGIONS(N_REGIONS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .reg_addr  (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .prot_open (prot_open),
      .op_done   (op_done),
      .op_fail   (op_fail),
      .rd_load   (rd_load),
      .rd_byte   (mem_rdata),
      .go        (go),
      .tgt_addr  (tgt_addr),
      .wr_byte   (wr_byte),
      .op_code   (op_code),
      .region_en (region_en)
   );

   generate
      if (N_REGIONS == 1) begin : g_one_region
         assign region_ok = region_en[0];
      end else begin : g_multi_region
         localparam int unsigned RB = $clog2(N_REGIONS);
         assign region_ok = region_en[tgt_addr[15 -: RB]];
      end
   endgenerate

   assign inhibit = bo_inhibit_cfg && bod_enable && vdd_low;

   fsp_ctrl #(
      .CW       (CW),
      .PROG_LD  (CW'(PROG_CYC - 1)),
      .ERASE_LD (CW'(ERASE_CYC - 1)),
      .READ_LD  (CW'(READ_CYC - 1))
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .op_code    (op_code),
      .region_ok  (region_ok),
      .inhibit    (inhibit),
      .expired    (expired),
      .timer_load (timer_load),
      .load_val   (load_val),
      .mem_req    (mem_req),
      .mem_commit (mem_commit),
      .op_done    (op_done),
      .op_fail    (op_fail)
   );

   fsp_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (load_val),
      .expired  (expired)
   );

   assign rd_load   = mem_commit && (op_code == OP_READ);
   assign cpu_stall = go;
   assign mem_op    = op_code;
   assign mem_addr  = tgt_addr;
   assign mem_wdata = wr_byte;

   assert_commit_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_commit |-> cpu_stall);

   assert_commit_region_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_commit && (mem_op == OP_PROG || mem_op == OP_ERASE)) |-> region_ok);

   assert_no_undefined_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_commit |-> (mem_op != OP_BAD));
endmodule

// File: tb/test_fsp_seq.sv
module test_fsp_seq;
   localparam int unsigned CLK_HZ = 2_000_000;
   localparam int PROG_LEN  = 47;     // 2 MHz * 23.5 us
   localparam int ERASE_LEN = 10000;  // 2 MHz * 5 ms
   localparam int PAGE      = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic prot_open = 1'b0;
   logic bo_inhibit_cfg = 1'b0, bod_enable = 1'b0, vdd_low = 1'b0;
   logic cpu_stall, mem_req, mem_commit;
   logic [1:0] mem_op;
   logic [15:0] mem_addr;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata = 8'hFF;

   int checks = 0, fails = 0;
   int commits = 0;
   logic [1:0] last_op;
   logic [15:0] last_addr;
   logic [7:0] last_data;
   logic [7:0] fmem [int];
   logic [3:0] rgn_mask = 4'b0000;
   bit finished = 0;

   always #4 clk = ~clk;

   fsp_seq #(.CLK_HZ(CLK_HZ)) i_fsp_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_open(prot_open),
      .bo_inhibit_cfg(bo_inhibit_cfg), .bod_enable(bod_enable), .vdd_low(vdd_low),
      .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_commit(mem_commit),
      .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] model_rd(input logic [15:0] a);
      return fmem.exists(int'(a)) ? fmem[int'(a)] : 8'hFF;
   endfunction

   function automatic bit exp_fail(input logic [1:0] op, input logic [15:0] a,
                                   input logic [3:0] mask, input bit bo);
      if (op == 2'b11) return 1;
      if ((op == 2'b01 || op == 2'b10) && (!mask[a[15:14]] || bo)) return 1;
      return 0;
   endfunction

   function automatic int exp_len(input logic [1:0] op, input bit fail);
      if (fail) return 2;
      case (op)
         2'b01:   return PROG_LEN + 2;
         2'b10:   return ERASE_LEN + 2;
         default: return 3;
      endcase
   endfunction

   always @(posedge clk) begin
      if (mem_commit) begin
         commits++;
         last_op   = mem_op;
         last_addr = mem_addr;
         last_data = mem_wdata;
         if (mem_op == 2'b01) fmem[int'(mem_addr)] = mem_wdata;
         if (mem_op == 2'b10) begin
            for (int i = 0; i < PAGE; i++) begin
               int k;
               k = int'({mem_addr[15:7], 7'd0}) + i;
               if (fmem.exists(k)) fmem.delete(k);
            end
         end
      end
   end

   task automatic print_summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pwr(input logic [2:0] a, input logic [7:0] d);
      prot_open = 1'b1;
      wr(a, d);
      prot_open = 1'b0;
   endtask

   task automatic wait_idle(output int len);
      len = 0;
      while (cpu_stall) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic run_op(input string req, input logic [15:0] a, input logic [7:0] d,
                         input logic [1:0] op, input bit bo);
      int c0, len;
      bit f;
      logic [7:0] v, want_rd;
      wr(3'd2, a[15:8]);
      wr(3'd3, a[7:0]);
      wr(3'd4, d);
      wr(3'd5, {6'd0, op});
      want_rd = model_rd(a);
      mem_rdata = want_rd;
      f = exp_fail(op, a, rgn_mask, bo);
      c0 = commits;
      pwr(3'd1, 8'h01);
      chk({req, " stall raised"}, cpu_stall, 1);
      wait_idle(len);
      chk({req, " stall length"}, len, exp_len(op, f));
      rd(3'd0, v);
      chk({req, " failure flag"}, v[1], f);
      chk({req, " commit count"}, commits - c0, f ? 0 : 1);
      rd(3'd1, v);
      chk({req, " start bit self-clear (R5)"}, v, 8'h00);
      if (!f && op == 2'b01) chk({req, " commit addr/data"}, {last_addr, last_data}, {a, d});
      if (!f && op == 2'b10) chk({req, " erase addr"}, {14'd0, last_op, last_addr}, {14'd0, 2'b10, a});
      if (!f && op == 2'b00) begin
         rd(3'd4, v);
         chk({req, " read capture"}, v, want_rd);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R5 watchdog: actual hung expected operation end");
         print_summary();
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      int len;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk("R1 register reset", v, 8'h00);
      end
      chk("R1 stall reset", {cpu_stall, mem_req, mem_commit}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: unprotected control write ignored
      wr(3'd0, 8'h01);
      rd(3'd0, v);
      chk("R2 unprotected enable write", v, 8'h00);
      // R3: start with enable clear does nothing
      pwr(3'd1, 8'h01);
      chk("R3 stall while disabled", cpu_stall, 0);
      rd(3'd1, v);
      chk("R3 start bit while disabled", v, 8'h00);
      pwr(3'd0, 8'h01);
      rd(3'd0, v);
      chk("R2 protected enable write", v, 8'h01);
      // R2: unprotected start write ignored
      wr(3'd1, 8'h01);
      chk("R2 unprotected start write", cpu_stall, 0);

      // R4: readback
      wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd4, 8'h96); wr(3'd5, 8'h02); wr(3'd6, 8'h0F);
      rd(3'd2, v); chk("R4 addr high", v, 8'hA5);
      rd(3'd3, v); chk("R4 addr low", v, 8'h3C);
      rd(3'd4, v); chk("R4 data", v, 8'h96);
      rd(3'd5, v); chk("R4 op code", v, 8'h02);
      rd(3'd6, v); chk("R4 region enables", v, 8'h0F);
      rgn_mask = 4'hF;

      run_op("R6 program", 16'h1234, 8'h5A, 2'b01, 0);
      run_op("R8 read back", 16'h1234, 8'h00, 2'b00, 0);
      run_op("R7 erase", 16'h1250, 8'h00, 2'b10, 0);
      run_op("R8 read erased", 16'h1234, 8'h00, 2'b00, 0);

      // R9: disabled region
      wr(3'd6, 8'h0B); rgn_mask = 4'hB;
      run_op("R9 program disabled region", 16'h8001, 8'h11, 2'b01, 0);
      run_op("R9 read disabled region", 16'h8001, 8'h00, 2'b00, 0);
      // R12: success clears flag
      run_op("R12 success clears flag", 16'h0002, 8'h22, 2'b01, 0);
      // R10
      run_op("R10 undefined code", 16'h0003, 8'h33, 2'b11, 0);
      // R12: writing 1 keeps, unprotected 0 ignored, protected 0 clears
      pwr(3'd0, 8'h03);
      rd(3'd0, v); chk("R12 write one keeps flag", v, 8'h03);
      wr(3'd0, 8'h01);
      rd(3'd0, v); chk("R12 unprotected clear ignored", v, 8'h03);
      pwr(3'd0, 8'h01);
      rd(3'd0, v); chk("R12 protected clear", v, 8'h01);
      pwr(3'd0, 8'h03);
      rd(3'd0, v); chk("R12 write one does not set", v, 8'h01);

      // R11: brown-out inhibit
      bo_inhibit_cfg = 1; bod_enable = 1; vdd_low = 1;
      run_op("R11 inhibited program", 16'h0010, 8'h44, 2'b01, 1);
      run_op("R11 read not inhibited", 16'h0010, 8'h00, 2'b00, 0);
      bod_enable = 0;
      run_op("R11 detection off", 16'h0011, 8'h45, 2'b01, 0);
      bod_enable = 1; bo_inhibit_cfg = 0;
      run_op("R11 inhibit unconfigured", 16'h0012, 8'h46, 2'b01, 0);
      bo_inhibit_cfg = 1; vdd_low = 0;
      run_op("R11 supply good", 16'h0013, 8'h47, 2'b01, 0);

      // R13: write during busy ignored
      wr(3'd3, 8'h20); wr(3'd5, 8'h01);
      pwr(3'd1, 8'h01);
      repeat (3) @(negedge clk);
      wr(3'd3, 8'h5A);
      chk("R13 still busy", cpu_stall, 1);
      wait_idle(len);
      rd(3'd3, v);
      chk("R13 busy write ignored", v, 8'h20);

      // random mix
      for (int n = 0; n < 30; n++) begin
         logic [15:0] a;
         logic [7:0] d;
         logic [1:0] op;
         bit bo;
         a = 16'($urandom);
         d = 8'($urandom);
         op = 2'($urandom);
         if (op == 2'b10 && ($urandom % 4) != 0) op = 2'b01;
         rgn_mask = 4'($urandom);
         wr(3'd6, {4'd0, rgn_mask});
         bo_inhibit_cfg = 1'($urandom); bod_enable = 1'($urandom); vdd_low = 1'($urandom);
         bo = bo_inhibit_cfg && bod_enable && vdd_low;
         run_op($sformatf("R9/R10/R11 random op %0d", n), a, d, op, bo);
      end

      finished = 1;
      print_summary();
      $finish;
   end
endmodule